// File: doc/BRIEF.md
# Line Threshold Interrupt Unit

This block raises one interrupt pin from a group of event sources and from a threshold monitor on the telephone line measurement. The monitor takes an 8-bit signed line-voltage sample and an 8-bit unsigned loop-current sample. Each pair arrives with a valid strobe. A select input picks which measurement is watched. The magnitude of the chosen value is compared with an 8-bit unsigned threshold. The monitor fires on a crossing, either upward or downward, as software chooses.

Every source, including the threshold monitor, has a sticky flag and a mask bit. A flag is set by its event and stays set until software pulses the matching write-one-to-clear strobe. The pin is asserted while any flag is set together with its mask bit, and only when the global enable is set. Its active level is programmable. The register bus that holds these configuration bits sits outside the block.

Top module: `line_irq_unit`

## Requirements
- R1: After reset all flags read 0, and `irq_o` is at its inactive level: 1 when `irq_pol_i`=0, 0 when `irq_pol_i`=1.
- R2: A 1 on bit k of `evt_i` sets `evt_flag_o[k]` at the next clock edge, whatever the value of the mask bit.
- R3: A flag holds its value until a 1 on its clear strobe (`evt_clr_i[k]` or `thr_clr_i`) clears it at the next edge. If a clear and a new event arrive in the same cycle, the flag is 1 after the edge.
- R4: The pin is active when `irq_en_i`=1 and at least one flag is 1 with its mask bit 1. The active level is low when `irq_pol_i`=0 and high when `irq_pol_i`=1. The pin is combinational from the flags, the masks, the enable and the polarity.
- R5: The monitored value is the voltage sample when `meas_sel_i`=0 and the current sample when `meas_sel_i`=1.
- R6: The voltage sample is two's complement, and its magnitude is its absolute value. The value -128 (0x80) maps to 127. The current sample is used as it is.
- R7: When `dir_rise_i`=1, a valid sample fires the monitor if the previous magnitude was at or below `thr_i` and the new magnitude is above it.
- R8: When `dir_rise_i`=0, a valid sample fires the monitor if the previous magnitude was at or above `thr_i` and the new magnitude is below it.
- R9: The first valid sample after reset never fires. Samples offered without `sample_valid_i` are ignored and do not replace the stored previous magnitude.
- R10: A magnitude that stays beyond the threshold over several samples sets `thr_flag_o` only on the crossing sample. When the monitor fires, `thr_flag_o` is 1 after the edge that takes the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| volt_i | input | 8 | Signed line-voltage sample |
| curr_i | input | 8 | Unsigned loop-current sample |
| sample_valid_i | input | 1 | Samples are valid this cycle |
| meas_sel_i | input | 1 | 0 selects voltage, 1 selects current |
| dir_rise_i | input | 1 | 1 fires on an upward crossing, 0 on a downward crossing |
| thr_i | input | 8 | Unsigned threshold |
| evt_i | input | N_EVT | Event pulses |
| evt_mask_i | input | N_EVT | Pin mask per event source |
| evt_clr_i | input | N_EVT | Write-one-to-clear strobes for the event flags |
| thr_mask_i | input | 1 | Pin mask for the threshold flag |
| thr_clr_i | input | 1 | Write-one-to-clear strobe for the threshold flag |
| irq_en_i | input | 1 | Global pin enable |
| irq_pol_i | input | 1 | 0 for an active-low pin, 1 for an active-high pin |
| evt_flag_o | output | N_EVT | Sticky event flags |
| thr_flag_o | output | 1 | Sticky threshold flag |
| irq_o | output | 1 | Interrupt pin |

## Verification
The hardest case to reach from the ports is the stored previous magnitude. It cannot be seen directly, and it decides whether a sample crosses. The bench therefore walks one long chain of samples without a reset between them. Each row's expected result depends on the row before it. The chain includes the switch between voltage and current and the -128 boundary at thresholds of 126 and 127. A directed case offers a sample without the strobe and then a strobed sample that fires only if the held value was kept.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int unsigned SMP_W = 8;

  typedef enum logic {
    SEL_VOLT = 1'b0,
    SEL_CURR = 1'b1
  } meas_sel_e;

  typedef logic [SMP_W-1:0] smp_t;
endpackage

// File: rtl/line_irq_mag.sv
module line_irq_mag #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] volt_i,
  input  logic [W-1:0] curr_i,
  input  logic         sel_i,
  output logic [W-1:0] mag_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] volt_abs;

  always_comb begin
    if (volt_i == MIN_NEG)  volt_abs = MAX_POS;  // saturate
    else if (volt_i[W-1])   volt_abs = -volt_i;
    else                    volt_abs = volt_i;
  end

  assign mag_o = (sel_i == line_irq_pkg::SEL_CURR) ? curr_i : volt_abs;
endmodule

// File: rtl/line_irq_cross.sv
module line_irq_cross #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         rise_i,
  input  logic [W-1:0] mag_i,
  input  logic [W-1:0] thr_i,
  output logic         fire_o
);
  logic [W-1:0] prev_q;
  logic         have_q;
  logic         up_x, dn_x;

  assign up_x   = (prev_q <= thr_i) && (mag_i > thr_i);
  assign dn_x   = (prev_q >= thr_i) && (mag_i < thr_i);
  assign fire_o = valid_i && have_q && (rise_i ? up_x : dn_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= mag_i;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/line_irq_flag.sv
module line_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/line_irq_unit.sv
module line_irq_unit #(
  parameter int unsigned N_EVT = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [line_irq_pkg::SMP_W-1:0] volt_i,
  input  logic [line_irq_pkg::SMP_W-1:0] curr_i,
  input  logic                           sample_valid_i,
  input  logic                           meas_sel_i,
  input  logic                           dir_rise_i,
  input  logic [line_irq_pkg::SMP_W-1:0] thr_i,
  input  logic [N_EVT-1:0]               evt_i,
  input  logic [N_EVT-1:0]               evt_mask_i,
  input  logic [N_EVT-1:0]               evt_clr_i,
  input  logic                           thr_mask_i,
  input  logic                           thr_clr_i,
  input  logic                           irq_en_i,
  input  logic                           irq_pol_i,
  output logic [N_EVT-1:0]               evt_flag_o,
  output logic                           thr_flag_o,
  output logic                           irq_o
);
  localparam int unsigned W     = line_irq_pkg::SMP_W;
  localparam int unsigned N_SRC = N_EVT + 1;

  logic [W-1:0]       mag;
  logic               thr_fire;
  logic [N_SRC-1:0]   src_set, src_clr, src_flag, src_mask;
  logic               irq_act;

  line_irq_mag #(.W(W)) u_mag (
    .volt_i (volt_i),
    .curr_i (curr_i),
    .sel_i  (meas_sel_i),
    .mag_o  (mag)
  );

  line_irq_cross #(.W(W)) u_cross (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .rise_i  (dir_rise_i),
    .mag_i   (mag),
    .thr_i   (thr_i),
    .fire_o  (thr_fire)
  );

  // top source bit is the threshold monitor
  assign src_set  = {thr_fire, evt_i};
  assign src_clr  = {thr_clr_i, evt_clr_i};
  assign src_mask = {thr_mask_i, evt_mask_i};

  for (genvar k = 0; k < N_SRC; k++) begin : g_flag
    line_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_set[k]),
      .clr_i  (src_clr[k]),
      .flag_o (src_flag[k])
    );
  end

  assign evt_flag_o = src_flag[N_EVT-1:0];
  assign thr_flag_o = src_flag[N_EVT];
  assign irq_act    = irq_en_i && |(src_flag & src_mask);
  assign irq_o      = irq_pol_i ? irq_act : ~irq_act;
endmodule

// File: rtl/line_irq_chk.sv
module line_irq_chk #(
  parameter int unsigned N_EVT = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_valid_i,
  input logic [N_EVT-1:0] evt_i,
  input logic [N_EVT-1:0] evt_mask_i,
  input logic [N_EVT-1:0] evt_clr_i,
  input logic             thr_mask_i,
  input logic             thr_clr_i,
  input logic             irq_en_i,
  input logic             irq_pol_i,
  input logic [N_EVT-1:0] evt_flag_o,
  input logic             thr_flag_o,
  input logic             irq_o
);
  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    // R2
    p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> evt_flag_o[k]);
    // R3
    p_sticky_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_flag_o[k] && !evt_clr_i[k]) |=> evt_flag_o[k]);
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_clr_i[k] && !evt_i[k]) |=> !evt_flag_o[k]);
  end

  // R9: the threshold flag only rises after a strobed sample
  p_thr_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_flag_o) |-> $past(sample_valid_i));

  // R3
  p_thr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_flag_o && !thr_clr_i) |=> thr_flag_o);

  // R4
  p_pin_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> (irq_o != irq_pol_i));
  p_pin_no_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_flag_o == '0) && !thr_flag_o) |-> (irq_o != irq_pol_i));
  p_pin_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && thr_flag_o && thr_mask_i) |-> (irq_o == irq_pol_i));
  p_pin_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && |(evt_flag_o & evt_mask_i)) |-> (irq_o == irq_pol_i));
endmodule

bind line_irq_unit line_irq_chk #(.N_EVT(N_EVT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .evt_i          (evt_i),
  .evt_mask_i     (evt_mask_i),
  .evt_clr_i      (evt_clr_i),
  .thr_mask_i     (thr_mask_i),
  .thr_clr_i      (thr_clr_i),
  .irq_en_i       (irq_en_i),
  .irq_pol_i      (irq_pol_i),
  .evt_flag_o     (evt_flag_o),
  .thr_flag_o     (thr_flag_o),
  .irq_o          (irq_o)
);

// File: tb/line_irq_unit_tb_top.sv
module line_irq_unit_tb_top;
  localparam int unsigned N_EVT = 6;
  localparam int unsigned N_VEC = 18;
  localparam int unsigned WDOG  = 20000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       volt_i = '0, curr_i = '0, thr_i = '0;
  logic             sample_valid_i = 1'b0, meas_sel_i = 1'b0, dir_rise_i = 1'b1;
  logic [N_EVT-1:0] evt_i = '0, evt_mask_i = '0, evt_clr_i = '0;
  logic             thr_mask_i = 1'b0, thr_clr_i = 1'b0;
  logic             irq_en_i = 1'b1, irq_pol_i = 1'b0;
  logic [N_EVT-1:0] evt_flag_o;
  logic             thr_flag_o, irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2ns clk_i = ~clk_i;  // 250 MHz

  line_irq_unit #(.N_EVT(N_EVT)) dut_i (.*);

  // row: {sel, rise, thr[7:0], volt[7:0], curr[7:0], expected flag}
  localparam logic [26:0] VEC [N_VEC] = '{
    {1'b0, 1'b1, 8'd50,  8'd10,   8'd0,   1'b0},  // R9 first sample
    {1'b0, 1'b1, 8'd50,  8'd60,   8'd0,   1'b1},  // R7
    {1'b0, 1'b1, 8'd50,  8'd70,   8'd0,   1'b0},  // R10
    {1'b0, 1'b1, 8'd50,  8'h9C,   8'd0,   1'b0},  // -100, R6 R10
    {1'b0, 1'b1, 8'd50,  8'd20,   8'd0,   1'b0},
    {1'b0, 1'b1, 8'd50,  8'hCD,   8'd0,   1'b1},  // -51, R6
    {1'b0, 1'b1, 8'd50,  8'd50,   8'd0,   1'b0},  // equal is not above
    {1'b0, 1'b1, 8'd50,  8'h80,   8'd0,   1'b1},  // -128 -> 127
    {1'b0, 1'b0, 8'd50,  8'd49,   8'd0,   1'b1},  // R8
    {1'b0, 1'b0, 8'd50,  8'd0,    8'd0,   1'b0},  // R10
    {1'b1, 1'b1, 8'd200, 8'h80,   8'd100, 1'b0},  // R5 current
    {1'b1, 1'b1, 8'd200, 8'd10,   8'd201, 1'b1},  // R5 R7
    {1'b1, 1'b1, 8'd200, 8'd0,    8'd255, 1'b0},
    {1'b1, 1'b0, 8'd200, 8'd0,    8'd199, 1'b1},  // R8
    {1'b0, 1'b1, 8'd126, 8'd0,    8'd250, 1'b0},
    {1'b0, 1'b1, 8'd126, 8'h80,   8'd0,   1'b1},  // R6 127 > 126
    {1'b0, 1'b1, 8'd127, 8'd0,    8'd0,   1'b0},
    {1'b0, 1'b1, 8'd127, 8'h80,   8'd250, 1'b0}   // R6 127 not > 127
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    check(evt_flag_o == '0 && !thr_flag_o, "R1 flags", int'(evt_flag_o), 0);
    check(irq_o == 1'b1, "R1 pin in reset", irq_o, 1);
    rst_ni = 1'b1;
    tick();
    check(irq_o == 1'b1, "R1 pin after reset", irq_o, 1);

    // table walk on the threshold monitor
    for (int i = 0; i < N_VEC; i++) begin
      {meas_sel_i, dir_rise_i, thr_i, volt_i, curr_i} = VEC[i][26:1];
      sample_valid_i = 1'b1;
      tick();
      sample_valid_i = 1'b0;
      check(thr_flag_o == VEC[i][0], $sformatf("R5-7-8-10 row %0d", i),
            thr_flag_o, VEC[i][0]);
      thr_clr_i = 1'b1;
      tick();
      thr_clr_i = 1'b0;
    end

    // R9: an unstrobed sample does not replace the held magnitude
    meas_sel_i = 1'b0; dir_rise_i = 1'b0; thr_i = 8'd50;
    volt_i = 8'd90; sample_valid_i = 1'b1; tick();
    sample_valid_i = 1'b0; thr_clr_i = 1'b1; tick(); thr_clr_i = 1'b0;
    volt_i = 8'd10; tick(); tick();
    check(thr_flag_o == 1'b0, "R9 unstrobed", thr_flag_o, 0);
    volt_i = 8'd40; sample_valid_i = 1'b1; tick(); sample_valid_i = 1'b0;
    check(thr_flag_o == 1'b1, "R9 held magnitude", thr_flag_o, 1);

    // R4 threshold mask drives the pin
    check(irq_o == 1'b1, "R4 thr masked", irq_o, 1);
    thr_mask_i = 1'b1; tick();
    check(irq_o == 1'b0, "R4 thr unmasked", irq_o, 0);
    thr_mask_i = 1'b0; thr_clr_i = 1'b1; tick(); thr_clr_i = 1'b0;
    check(thr_flag_o == 1'b0, "R3 thr clear", thr_flag_o, 0);

    // R2 event sets flag with mask off; pin stays idle
    evt_i = 6'b000100; tick(); evt_i = '0;
    check(evt_flag_o == 6'b000100, "R2 set", int'(evt_flag_o), 4);
    check(irq_o == 1'b1, "R4 masked event", irq_o, 1);
    repeat (3) tick();
    check(evt_flag_o == 6'b000100, "R3 sticky", int'(evt_flag_o), 4);
    evt_mask_i = 6'b000100; tick();
    check(irq_o == 1'b0, "R4 active low", irq_o, 0);
    irq_pol_i = 1'b1; tick();
    check(irq_o == 1'b1, "R4 active high", irq_o, 1);
    irq_en_i = 1'b0; tick();
    check(irq_o == 1'b0, "R4 disabled", irq_o, 0);
    irq_en_i = 1'b1; irq_pol_i = 1'b0;

    // R3 clear and set together: set wins
    evt_clr_i = 6'b000100; evt_i = 6'b000100; tick();
    evt_clr_i = '0; evt_i = '0;
    check(evt_flag_o[2] == 1'b1, "R3 set wins", evt_flag_o[2], 1);
    evt_clr_i = 6'b000100; tick(); evt_clr_i = '0;
    check(evt_flag_o == '0, "R3 cleared", int'(evt_flag_o), 0);
    check(irq_o == 1'b1, "R4 idle after clear", irq_o, 1);

    // R2 several sources at once, clear one
    evt_i = 6'b100001; tick(); evt_i = '0;
    check(evt_flag_o == 6'b100001, "R2 two sources", int'(evt_flag_o), 33);
    evt_clr_i = 6'b000001; tick(); evt_clr_i = '0;
    check(evt_flag_o == 6'b100000, "R3 one cleared", int'(evt_flag_o), 32);

    finish_run();
  end
endmodule